// File: doc/BRIEF.md
# Tracker Busy Guard

This block sits in the trigger path and decides when the trigger logic must hold off. The tracker interface unit raises a busy line while it is digesting an event. The guard brings that line into the local clock domain and combines it with a minimum-deadtime timer that restarts on every accepted trigger. The result is a single inhibit output. Two controls remove the external busy from that decision: an ignore control, for a line known to be stuck, and a minimum-deadtime mode, in which only the deadtime timer can inhibit.

For bench work or when the tracker is absent, an emulator can stand in for the external line. It goes busy on each trigger for a programmed number of cycles. The guard also watches the busy source, whether external or emulated, for monitoring. It reports whether the source has been stuck high, how long the most recent completed busy period lasted, and how many busy cycles fell inside the last fixed-length measurement window. A link-up indication is synchronised and reported inverted as a link-bad flag.

Top module: `trk_busy_guard`

## Requirements
- R1: Directly after reset with all inputs low: inhibit_o=0, stuck_o=0, last_len_o=0, rate_o=0 and link_bad_o=1.
- R2: A trig_i pulse sampled at a clock edge loads the deadtime timer with dead_len_i. inhibit_o is then high for exactly dead_len_i cycles, counted from that edge. A new trigger reloads the timer. A dead_len_i of 0 adds no inhibit.
- R3: With emulation off and neither override set, ext_busy_i reaches inhibit_o after two clock edges of synchronisation, both when it rises and when it falls.
- R4: While ignore_busy_i=1, the external busy has no effect on inhibit_o.
- R5: While min_dead_mode_i=1, neither the external busy nor the emulated busy affects inhibit_o. Only the deadtime timer does.
- R6: While emu_en_i=1, ext_busy_i is not used. A trigger makes the emulated busy high for exactly emu_len_i cycles. Clearing emu_en_i discards any emulated busy still pending.
- R7: last_len_o holds the number of consecutive cycles the busy source was high in its most recent completed high period. It updates one cycle after the source falls.
- R8: stuck_o rises once the busy source has been high for STUCK_CYC consecutive cycles. It clears within one cycle of the source falling. ignore_busy_i does not mask it.
- R9: At the end of every window of WIN_CYC cycles, rate_o takes the number of cycles in that window in which the busy source was high, saturating at the counter's maximum.
- R10: link_bad_o is the inverse of link_up_i delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Accepted-trigger pulse |
| ext_busy_i | input | 1 | Busy line from the tracker interface (asynchronous) |
| link_up_i | input | 1 | Link-up indication from the physical link (asynchronous) |
| emu_en_i | input | 1 | Replace the external busy by the emulator |
| ignore_busy_i | input | 1 | Disregard the busy source for inhibit |
| min_dead_mode_i | input | 1 | Inhibit from the deadtime timer only |
| emu_len_i | input | EMU_LEN_W | Emulated busy length in cycles |
| dead_len_i | input | DEAD_LEN_W | Minimum deadtime in cycles |
| inhibit_o | output | 1 | Trigger inhibit |
| stuck_o | output | 1 | Busy source high for too long |
| link_bad_o | output | 1 | Link not working |
| last_len_o | output | LEN_W | Length of the last completed busy period |
| rate_o | output | RATE_W | Busy cycles in the last window |

## Verification
The inhibit path is tried with a single trigger, with a trigger repeated while the timer is still running, and with a zero deadtime. These three separate a timer that reloads from one that ignores a new trigger or counts one cycle too many or too few. The external line is driven as a short pulse, to pin down the two-edge latency and the measured length. It is then held high past the stuck limit with ignore set, which shows that monitoring and inhibit are decoupled. The emulator runs alone, overlapped with a shorter deadtime, and under minimum-deadtime mode, so that union and masking are told apart; switching it off mid-period checks that pending busy is discarded. The rate counter sees a cycle-by-cycle toggle, a constant high and a constant low, which yield half, full and zero counts whatever the window alignment.

// File: rtl/trk_busy_pkg.sv
package trk_busy_pkg;

  localparam int EMU_LEN_W_DEF  = 18;
  localparam int DEAD_LEN_W_DEF = 20;
  localparam int LEN_W_DEF      = 32;
  localparam int RATE_W_DEF     = 24;
  localparam int SYNC_STAGES    = 2;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_EMU = 1'b1
  } busy_src_e;

  function automatic busy_src_e pick_source(input logic emu_en);
    return emu_en ? SRC_EMU : SRC_EXT;
  endfunction

  function automatic logic busy_counts_for_inhibit(input logic ignore_busy,
                                                   input logic min_dead_mode);
    return !(ignore_busy || min_dead_mode);
  endfunction

endpackage

// File: rtl/trk_sync.sv
module trk_sync #(
  parameter int          STAGES  = 2,
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= RST_VAL;
    else        stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/trk_countdown.sv
module trk_countdown #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         active_o
);

  logic [W-1:0] remain_q;

  function automatic logic [W-1:0] step_down(input logic [W-1:0] v);
    return (v == '0) ? '0 : v - W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      remain_q <= '0;
    else if (clr_i)  remain_q <= '0;
    else if (load_i) remain_q <= len_i;
    else             remain_q <= step_down(remain_q);
  end

  assign active_o = (remain_q != '0);

endmodule

// File: rtl/trk_busy_mon.sv
module trk_busy_mon #(
  parameter int LEN_W     = 32,
  parameter int RATE_W    = 24,
  parameter int STUCK_CYC = 100_000,
  parameter int WIN_CYC   = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  output logic              fall_evt_o,
  output logic              win_end_o,
  output logic              stuck_o,
  output logic [LEN_W-1:0]  last_len_o,
  output logic [RATE_W-1:0] rate_o
);

  localparam int WIN_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
  localparam logic [LEN_W-1:0] STUCK_LIM = LEN_W'(STUCK_CYC);

  function automatic logic [LEN_W-1:0] len_inc(input logic [LEN_W-1:0] v);
    return (v == '1) ? v : v + LEN_W'(1);
  endfunction

  function automatic logic [RATE_W-1:0] rate_add(input logic [RATE_W-1:0] v,
                                                 input logic inc);
    return (v == '1 || !inc) ? v : v + RATE_W'(1);
  endfunction

  logic              busy_prev_q;
  logic [LEN_W-1:0]  run_q;
  logic [WIN_W-1:0]  win_q;
  logic [RATE_W-1:0] acc_q;

  assign fall_evt_o = busy_prev_q && !busy_i;
  assign win_end_o  = (win_q == WIN_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) busy_prev_q <= 1'b0;
    else        busy_prev_q <= busy_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_i) run_q <= len_inc(run_q);
    else             run_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          last_len_o <= '0;
    else if (fall_evt_o) last_len_o <= run_q;
  end

  assign stuck_o = (run_q >= STUCK_LIM) && (run_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      acc_q  <= '0;
      rate_o <= '0;
    end else if (win_end_o) begin
      win_q  <= '0;
      acc_q  <= '0;
      rate_o <= rate_add(acc_q, busy_i);
    end else begin
      win_q  <= win_q + WIN_W'(1);
      acc_q  <= rate_add(acc_q, busy_i);
    end
  end

endmodule

// File: rtl/trk_busy_guard.sv
module trk_busy_guard
  import trk_busy_pkg::*;
#(
  parameter int EMU_LEN_W  = EMU_LEN_W_DEF,
  parameter int DEAD_LEN_W = DEAD_LEN_W_DEF,
  parameter int LEN_W      = LEN_W_DEF,
  parameter int RATE_W     = RATE_W_DEF,
  parameter int STUCK_CYC  = 100_000,
  parameter int WIN_CYC    = 100_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_i,
  input  logic                  ext_busy_i,
  input  logic                  link_up_i,
  input  logic                  emu_en_i,
  input  logic                  ignore_busy_i,
  input  logic                  min_dead_mode_i,
  input  logic [EMU_LEN_W-1:0]  emu_len_i,
  input  logic [DEAD_LEN_W-1:0] dead_len_i,
  output logic                  inhibit_o,
  output logic                  stuck_o,
  output logic                  link_bad_o,
  output logic [LEN_W-1:0]      last_len_o,
  output logic [RATE_W-1:0]     rate_o
);

  logic [1:0] async_in;
  logic [1:0] sync_out;
  logic       ext_busy_s;
  logic       link_up_s;
  logic       emu_busy;
  logic       dead_active;
  logic       src_busy;
  logic       eff_busy;
  logic       fall_evt;
  logic       win_end;
  busy_src_e  src_sel;

  assign async_in = {link_up_i, ext_busy_i};

  trk_sync #(
    .STAGES  (SYNC_STAGES),
    .WIDTH   (2),
    .RST_VAL (2'b00)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (async_in),
    .q_o   (sync_out)
  );

  assign ext_busy_s = sync_out[0];
  assign link_up_s  = sync_out[1];
  assign link_bad_o = !link_up_s;

  trk_countdown #(.W(EMU_LEN_W)) u_emu (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (!emu_en_i),
    .load_i   (trig_i),
    .len_i    (emu_len_i),
    .active_o (emu_busy)
  );

  trk_countdown #(.W(DEAD_LEN_W)) u_dead (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (1'b0),
    .load_i   (trig_i),
    .len_i    (dead_len_i),
    .active_o (dead_active)
  );

  assign src_sel   = pick_source(emu_en_i);
  assign src_busy  = (src_sel == SRC_EMU) ? emu_busy : ext_busy_s;
  assign eff_busy  = src_busy && busy_counts_for_inhibit(ignore_busy_i, min_dead_mode_i);
  assign inhibit_o = dead_active || eff_busy;

  trk_busy_mon #(
    .LEN_W     (LEN_W),
    .RATE_W    (RATE_W),
    .STUCK_CYC (STUCK_CYC),
    .WIN_CYC   (WIN_CYC)
  ) u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (src_busy),
    .fall_evt_o (fall_evt),
    .win_end_o  (win_end),
    .stuck_o    (stuck_o),
    .last_len_o (last_len_o),
    .rate_o     (rate_o)
  );

endmodule

// File: rtl/trk_busy_guard_chk.sv
module trk_busy_guard_chk #(
  parameter int EMU_LEN_W  = 18,
  parameter int DEAD_LEN_W = 20,
  parameter int LEN_W      = 32,
  parameter int RATE_W     = 24,
  parameter int WIN_CYC    = 100_000_000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  trig_i,
  input logic                  emu_en_i,
  input logic                  ignore_busy_i,
  input logic                  min_dead_mode_i,
  input logic [EMU_LEN_W-1:0]  emu_len_i,
  input logic [DEAD_LEN_W-1:0] dead_len_i,
  input logic                  inhibit_o,
  input logic                  stuck_o,
  input logic [LEN_W-1:0]      last_len_o,
  input logic [RATE_W-1:0]     rate_o,
  input logic                  dead_active,
  input logic                  src_busy,
  input logic                  fall_evt,
  input logic                  win_end
);

  assert_dead_after_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && dead_len_i != '0) |=> inhibit_o);

  // R4 and R5: overrides leave only the timer able to inhibit
  assert_override_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dead_active && (ignore_busy_i || min_dead_mode_i)) |-> !inhibit_o);

  assert_emu_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_en_i && trig_i && emu_len_i != '0) |=> (!emu_en_i || src_busy));

  assert_len_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_len_o) |-> $past(fall_evt));

  assert_stuck_needs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_o |-> $past(src_busy));

  assert_rate_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    longint'(rate_o) <= longint'(WIN_CYC));

  assert_rate_on_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_o) |-> $past(win_end));

endmodule

bind trk_busy_guard trk_busy_guard_chk #(
  .EMU_LEN_W  (EMU_LEN_W),
  .DEAD_LEN_W (DEAD_LEN_W),
  .LEN_W      (LEN_W),
  .RATE_W     (RATE_W),
  .WIN_CYC    (WIN_CYC)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .trig_i          (trig_i),
  .emu_en_i        (emu_en_i),
  .ignore_busy_i   (ignore_busy_i),
  .min_dead_mode_i (min_dead_mode_i),
  .emu_len_i       (emu_len_i),
  .dead_len_i      (dead_len_i),
  .inhibit_o       (inhibit_o),
  .stuck_o         (stuck_o),
  .last_len_o      (last_len_o),
  .rate_o          (rate_o),
  .dead_active     (dead_active),
  .src_busy        (src_busy),
  .fall_evt        (fall_evt),
  .win_end         (win_end)
);

// File: tb/trk_busy_guard_tb.sv
`timescale 1ns/1ps
module trk_busy_guard_tb;

  localparam int STUCK = 20;
  localparam int WIN   = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_i = 1'b0;
  logic        ext_busy_i = 1'b0;
  logic        link_up_i = 1'b0;
  logic        emu_en_i = 1'b0;
  logic        ignore_busy_i = 1'b0;
  logic        min_dead_mode_i = 1'b0;
  logic [17:0] emu_len_i = '0;
  logic [19:0] dead_len_i = '0;
  logic        inhibit_o;
  logic        stuck_o;
  logic        link_bad_o;
  logic [31:0] last_len_o;
  logic [23:0] rate_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trk_busy_guard #(.STUCK_CYC(STUCK), .WIN_CYC(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .ext_busy_i(ext_busy_i),
    .link_up_i(link_up_i), .emu_en_i(emu_en_i), .ignore_busy_i(ignore_busy_i),
    .min_dead_mode_i(min_dead_mode_i), .emu_len_i(emu_len_i),
    .dead_len_i(dead_len_i), .inhibit_o(inhibit_o), .stuck_o(stuck_o),
    .link_bad_o(link_bad_o), .last_len_o(last_len_o), .rate_o(rate_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fire_and_count(input int n, output int hits);
    @(negedge clk) trig_i = 1'b1;
    @(negedge clk) trig_i = 1'b0;
    hits = 0;
    for (int i = 0; i < n; i++) begin
      if (inhibit_o) hits++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 inhibit", inhibit_o, 0);
    chk("R1 stuck", stuck_o, 0);
    chk("R1 last_len", last_len_o, 0);
    chk("R1 rate", rate_o, 0);
    chk("R1 link_bad", link_bad_o, 1);
  endtask

  task automatic t_link();
    @(negedge clk) link_up_i = 1'b1;
    @(negedge clk) chk("R10 one edge", link_bad_o, 1);
    @(negedge clk) chk("R10 two edges", link_bad_o, 0);
  endtask

  task automatic t_deadtime();
    int h;
    dead_len_i = 20'd5;
    fire_and_count(12, h);
    chk("R2 single trigger", h, 5);
    dead_len_i = 20'd0;
    fire_and_count(8, h);
    chk("R2 zero deadtime", h, 0);
  endtask

  task automatic t_retrigger();
    int h = 0;
    dead_len_i = 20'd6;
    @(negedge clk) trig_i = 1'b1;
    @(negedge clk) trig_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (inhibit_o) h++;
      trig_i = (i == 2);
      @(negedge clk);
    end
    trig_i = 1'b0;
    chk("R2 retrigger reload", h, 9);
    dead_len_i = 20'd0;
  endtask

  task automatic t_ext_busy();
    @(negedge clk) ext_busy_i = 1'b1;
    @(negedge clk) chk("R3 rise after one edge", inhibit_o, 0);
    @(negedge clk) chk("R3 rise after two edges", inhibit_o, 1);
    ext_busy_i = 1'b0;
    @(negedge clk) chk("R3 fall after one edge", inhibit_o, 1);
    @(negedge clk) chk("R3 fall after two edges", inhibit_o, 0);
    idle(3);
    chk("R7 short pulse length", last_len_o, 2);
  endtask

  task automatic t_ignore_stuck();
    @(negedge clk) ignore_busy_i = 1'b1;
    ext_busy_i = 1'b1;
    idle(29);
    chk("R8 stuck set", stuck_o, 1);
    chk("R4 ignore masks busy", inhibit_o, 0);
    @(negedge clk) ext_busy_i = 1'b0;
    idle(6);
    chk("R8 stuck cleared", stuck_o, 0);
    chk("R7 long period length", last_len_o, 30);
    ignore_busy_i = 1'b0;
    idle(2);
  endtask

  task automatic t_emulator();
    int h;
    @(negedge clk) emu_en_i = 1'b1;
    ext_busy_i = 1'b1;
    emu_len_i = 18'd8;
    dead_len_i = 20'd0;
    idle(3);
    chk("R6 external busy unused", inhibit_o, 0);
    fire_and_count(20, h);
    chk("R6 emulated length", h, 8);
    chk("R7 emulated period length", last_len_o, 8);
    dead_len_i = 20'd3;
    fire_and_count(20, h);
    chk("R2 R6 union", h, 8);
    min_dead_mode_i = 1'b1;
    fire_and_count(20, h);
    chk("R5 min-dead masks emulator", h, 3);
    min_dead_mode_i = 1'b0;
    dead_len_i = 20'd0;
    ext_busy_i = 1'b0;
    emu_len_i = 18'd50;
    idle(4);
    @(negedge clk) trig_i = 1'b1;
    @(negedge clk) trig_i = 1'b0;
    idle(2);
    chk("R6 emulated busy running", inhibit_o, 1);
    emu_en_i = 1'b0;
    @(negedge clk) emu_en_i = 1'b1;
    @(negedge clk) chk("R6 pending discarded", inhibit_o, 0);
    emu_en_i = 1'b0;
    idle(3);
  endtask

  task automatic t_min_dead_ext();
    @(negedge clk) min_dead_mode_i = 1'b1;
    ext_busy_i = 1'b1;
    idle(4);
    chk("R5 min-dead masks external", inhibit_o, 0);
    ext_busy_i = 1'b0;
    min_dead_mode_i = 1'b0;
    idle(4);
  endtask

  task automatic t_rate();
    for (int i = 0; i < 3 * WIN; i++) begin
      @(negedge clk) ext_busy_i = ~ext_busy_i;
    end
    chk("R9 toggling half", rate_o, WIN / 2);
    @(negedge clk) ext_busy_i = 1'b1;
    idle(3 * WIN);
    chk("R9 constant high", rate_o, WIN);
    ext_busy_i = 1'b0;
    idle(3 * WIN);
    chk("R9 constant low", rate_o, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_link();
    t_deadtime();
    t_retrigger();
    t_ext_busy();
    t_ignore_stuck();
    t_emulator();
    t_min_dead_ext();
    t_rate();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule